// File: doc/BRIEF.md
# Multi-level Page Table Walker

The block converts a 64-bit virtual address into a real address by chasing a chain of translation tables held in memory. A walk can pass through up to four table tiers above the page table (the outer region tier, the middle region tier, the inner region tier and the segment tier) and then the page table itself. The depth is chosen by the type field of the address-space control element. That element is picked from one of three control-register inputs according to the requested address-space mode.

A client presents one request at a time: the virtual address, the kind of access (read, write or instruction fetch), the address-space mode, a translation-enable flag and a wide-address flag. The walker reads table entries one at a time through a 64-bit memory read port. It finishes with a single-cycle done pulse that carries the real address and read/write/execute permissions, or with a single-cycle fault pulse that carries a fault code and a translation-exception word. Real addresses below 0x2000 are moved by a prefix register before they are reported.

Top module: `ptw_top`

## Requirements
- R1: After reset `req_ready_o`=1 and `done_o`, `fault_o` and `mem_req_o` are 0. A request is taken while `req_ready_o` is high. Each request ends in exactly one single-cycle pulse of either `done_o` or `fault_o`, never both.
- R2: With `req_xlat_en_i`=0 the walk reads no memory. It ends with `done_o`, the real address equals the page-aligned virtual address (bits 11:0 cleared), and read, write and execute are all granted. The mode is then ignored.
- R3: With `req_wide_i`=0 the page-aligned virtual address is ANDed with 0x7FFFFFFF before any other use.
- R4: Mode encoding on `req_mode_i`: 0 primary (uses `cr_primary_i`), 2 secondary (uses `cr_secondary_i`), 3 home (uses `cr_home_i`). Mode 1 with translation enabled faults with code 0x7F, word equal to the virtual address, and no memory read.
- R5: The control element type sits in bits 3:2: 3 outer region, 2 middle region, 1 inner region, 0 segment. Before any read, type 2 requires va & 0xFFE0000000000000 = 0, type 1 requires va & 0xFFFFFC0000000000 = 0, and type 0 requires va & 0xFFFFFFFF80000000 = 0. A failure faults with code 0x12 and no read.
- R6: A control element with bit 5 set gives a real address equal to the virtual address, with no table reads.
- R7: Walk order: the first read is at origin(control element) + off(type). Each further read is at origin(entry) + off(next tier), down to the page table. The origin of any element is its bits 63:12 with 11:0 cleared. The byte offsets are: outer (va>>50)&0x3FF8, middle (va>>39)&0x3FF8, inner (va>>28)&0x3FF8, segment (va>>17)&0x3FF8, page (va>>9)&0x07F8. A full walk from type t issues exactly t+2 reads.
- R8: A region or segment entry with bit 5 set faults with code 0x10. A non-invalid entry whose type field (bits 3:2) differs from the tier of the table it was read from faults with code 0x12.
- R9: A page entry with bit 10 set faults with code 0x11. Otherwise the real address is the page entry's origin, and bit 9 set removes write permission.
- R10: In secondary mode an instruction fetch (access code 2) walks through `cr_primary_i` and loses read and write permission. A read (0) or write (1) walks through `cr_secondary_i` and loses execute permission.
- R11: A write (access code 1) that ends on a page without write permission faults with code 0x04 and word va | mode code | 4.
- R12: The mode code is 1 for primary and for a secondary-mode fetch, 2 for secondary data, and 3 for home. Translation faults (0x10, 0x11, 0x12) report the word va | mode code, where va is the page-aligned, masked virtual address.
- R13: A real address below 0x2000 is reported with `prefix_i` added to it.
- R14: At most one memory read is outstanding. `mem_req_o` and `mem_addr_o` hold steady until `mem_rvalid_i`, and `mem_req_o` is never high while `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | 64 | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_mode_i | input | 2 | Address-space mode |
| req_xlat_en_i | input | 1 | Translation enable |
| req_wide_i | input | 1 | 64-bit addressing; 0 masks to 31 bits |
| cr_primary_i | input | 64 | Primary-space control element |
| cr_secondary_i | input | 64 | Secondary-space control element |
| cr_home_i | input | 64 | Home-space control element |
| prefix_i | input | 64 | Prefix added to low real addresses |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 64 | Table entry address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Table entry read |
| done_o | output | 1 | Translation finished pulse |
| real_addr_o | output | 64 | Resulting real address |
| perm_r_o | output | 1 | Read permitted |
| perm_w_o | output | 1 | Write permitted |
| perm_x_o | output | 1 | Execute permitted |
| fault_o | output | 1 | Translation fault pulse |
| fault_code_o | output | 8 | Fault code |
| fault_word_o | output | 64 | Translation-exception word |

## Verification
The assertions assume that the memory side returns `mem_rvalid_i` only while `mem_req_o` is high, and at most one pulse per request. They also assume that `req_acc_i` stays within the three defined codes. The bench memory model answers only a pending request, with a programmable number of wait cycles, and drops its valid flag on the cycle after each answer. The directed tasks drive only access codes 0 to 2. Table contents are built by the bench from the offset rules, and unmapped addresses read back as an entry with every invalid bit set.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  parameter int unsigned VA_W     = 64;
  parameter int unsigned PG_SHIFT = 12;
  parameter int unsigned FC_W     = 8;
  localparam logic [VA_W-1:0] LOW_LIMIT = VA_W'(64'h2000);
  localparam logic [VA_W-1:0] MASK31    = VA_W'(64'h7FFF_FFFF);

  localparam int unsigned TYPE_LSB   = 2;
  localparam int unsigned INV_BIT    = 5;
  localparam int unsigned REAL_BIT   = 5;
  localparam int unsigned PTE_INV    = 10;
  localparam int unsigned PTE_RO     = 9;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_FX = 2'd2;

  localparam logic [1:0] AS_PRI  = 2'd0;
  localparam logic [1:0] AS_AR   = 2'd1;
  localparam logic [1:0] AS_SEC  = 2'd2;
  localparam logic [1:0] AS_HOME = 2'd3;

  localparam logic [FC_W-1:0] FC_PROT = 8'h04;
  localparam logic [FC_W-1:0] FC_SEG  = 8'h10;
  localparam logic [FC_W-1:0] FC_PAGE = 8'h11;
  localparam logic [FC_W-1:0] FC_SPEC = 8'h12;
  localparam logic [FC_W-1:0] FC_MODE = 8'h7F;

  typedef enum logic [1:0] {W_IDLE, W_START, W_MEM} walk_st_e;

  function automatic logic [VA_W-1:0] origin_of(input logic [VA_W-1:0] e);
    return {e[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  endfunction

  function automatic logic [1:0] type_of(input logic [VA_W-1:0] e);
    return e[TYPE_LSB+1:TYPE_LSB];
  endfunction

  // byte offset of the entry inside the table of tier lvl (3 outer .. 0 segment)
  function automatic logic [VA_W-1:0] tbl_off(input logic [1:0] lvl, input logic [VA_W-1:0] va);
    logic [VA_W-1:0] r;
    case (lvl)
      2'd3:    r = (va >> 50) & VA_W'(64'h3FF8);
      2'd2:    r = (va >> 39) & VA_W'(64'h3FF8);
      2'd1:    r = (va >> 28) & VA_W'(64'h3FF8);
      default: r = (va >> 17) & VA_W'(64'h3FF8);
    endcase
    return r;
  endfunction

  function automatic logic [VA_W-1:0] pte_off(input logic [VA_W-1:0] va);
    return (va >> 9) & VA_W'(64'h07F8);
  endfunction

  function automatic logic range_bad(input logic [1:0] t, input logic [VA_W-1:0] va);
    logic r;
    case (t)
      2'd2:    r = |(va & VA_W'(64'hFFE0_0000_0000_0000));
      2'd1:    r = |(va & VA_W'(64'hFFFF_FC00_0000_0000));
      2'd0:    r = |(va & VA_W'(64'hFFFF_FFFF_8000_0000));
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ptw_front.sv
module ptw_front
  import ptw_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic [VA_W-1:0] va_i,
  input  logic [1:0]      acc_i,
  input  logic [1:0]      mode_i,
  input  logic            en_i,
  input  logic            wide_i,
  input  logic [VA_W-1:0] cr_pri_i,
  input  logic [VA_W-1:0] cr_sec_i,
  input  logic [VA_W-1:0] cr_home_i,
  output logic [VA_W-1:0] va_o,
  output logic [VA_W-1:0] ce_o,
  output logic [1:0]      acc_o,
  output logic [1:0]      code_o,
  output logic            en_o,
  output logic            mode_bad_o,
  output logic            sec_fx_o,
  output logic            sec_dat_o
);
  logic [VA_W-1:0] va_pg, ce_sel;
  logic [1:0]      code_sel;
  logic            is_fx;

  always_comb begin
    va_pg = {va_i[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
    if (!wide_i) va_pg = va_pg & MASK31;
    is_fx = (acc_i == ACC_FX);
    case (mode_i)
      AS_PRI:  begin ce_sel = cr_pri_i;  code_sel = 2'd1; end
      AS_SEC:  begin
        ce_sel   = is_fx ? cr_pri_i : cr_sec_i;
        code_sel = is_fx ? 2'd1 : 2'd2;
      end
      AS_HOME: begin ce_sel = cr_home_i; code_sel = 2'd3; end
      default: begin ce_sel = '0;        code_sel = 2'd0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_o       <= '0;
      ce_o       <= '0;
      acc_o      <= ACC_RD;
      code_o     <= '0;
      en_o       <= 1'b0;
      mode_bad_o <= 1'b0;
      sec_fx_o   <= 1'b0;
      sec_dat_o  <= 1'b0;
    end else if (accept_i) begin
      va_o       <= va_pg;
      ce_o       <= ce_sel;
      acc_o      <= acc_i;
      code_o     <= code_sel;
      en_o       <= en_i;
      mode_bad_o <= (mode_i == AS_AR);
      sec_fx_o   <= (mode_i == AS_SEC) && is_fx;
      sec_dat_o  <= (mode_i == AS_SEC) && !is_fx;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            ready_o,
  output logic            accept_o,
  input  logic            en_i,
  input  logic            mode_bad_i,
  input  logic [VA_W-1:0] va_i,
  input  logic [VA_W-1:0] ce_i,
  output logic            mem_req_o,
  output logic [VA_W-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [VA_W-1:0] mem_rdata_i,
  output logic            fin_o,
  output logic            fin_fault_o,
  output logic [FC_W-1:0] fin_code_o,
  output logic [VA_W-1:0] fin_real_o,
  output logic            fin_ro_o
);
  walk_st_e        st_q, st_d;
  logic [1:0]      lvl_q, lvl_d;
  logic            pg_q, pg_d;
  logic [VA_W-1:0] addr_q, addr_d;

  assign ready_o    = (st_q == W_IDLE);
  assign accept_o   = ready_o && req_valid_i;
  assign mem_req_o  = (st_q == W_MEM);
  assign mem_addr_o = addr_q;

  always_comb begin
    st_d        = st_q;
    lvl_d       = lvl_q;
    pg_d        = pg_q;
    addr_d      = addr_q;
    fin_o       = 1'b0;
    fin_fault_o = 1'b0;
    fin_code_o  = '0;
    fin_real_o  = va_i;
    fin_ro_o    = 1'b0;
    case (st_q)
      W_IDLE: if (req_valid_i) st_d = W_START;
      W_START: begin
        st_d = W_IDLE;
        if (!en_i) begin
          fin_o = 1'b1;
        end else if (mode_bad_i) begin
          fin_o = 1'b1; fin_fault_o = 1'b1; fin_code_o = FC_MODE;
        end else if (range_bad(type_of(ce_i), va_i)) begin
          fin_o = 1'b1; fin_fault_o = 1'b1; fin_code_o = FC_SPEC;
        end else if (ce_i[REAL_BIT]) begin
          fin_o = 1'b1;
        end else begin
          lvl_d  = type_of(ce_i);
          pg_d   = 1'b0;
          addr_d = origin_of(ce_i) + tbl_off(type_of(ce_i), va_i);
          st_d   = W_MEM;
        end
      end
      W_MEM: if (mem_rvalid_i) begin
        if (pg_q) begin
          st_d  = W_IDLE;
          fin_o = 1'b1;
          if (mem_rdata_i[PTE_INV]) begin
            fin_fault_o = 1'b1; fin_code_o = FC_PAGE;
          end else begin
            fin_real_o = origin_of(mem_rdata_i);
            fin_ro_o   = mem_rdata_i[PTE_RO];
          end
        end else if (mem_rdata_i[INV_BIT]) begin
          st_d = W_IDLE; fin_o = 1'b1; fin_fault_o = 1'b1; fin_code_o = FC_SEG;
        end else if (type_of(mem_rdata_i) != lvl_q) begin
          st_d = W_IDLE; fin_o = 1'b1; fin_fault_o = 1'b1; fin_code_o = FC_SPEC;
        end else if (lvl_q == 2'd0) begin
          pg_d   = 1'b1;
          addr_d = origin_of(mem_rdata_i) + pte_off(va_i);
        end else begin
          lvl_d  = lvl_q - 2'd1;
          addr_d = origin_of(mem_rdata_i) + tbl_off(lvl_q - 2'd1, va_i);
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= W_IDLE;
      lvl_q  <= '0;
      pg_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      lvl_q  <= lvl_d;
      pg_q   <= pg_d;
      addr_q <= addr_d;
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o)); // R14
  AST_NO_READ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o); // R14
  AST_OFF_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == W_START) && !en_i |=> !mem_req_o); // R2
endmodule

// File: rtl/ptw_finish.sv
module ptw_finish
  import ptw_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fin_i,
  input  logic            fin_fault_i,
  input  logic [FC_W-1:0] fin_code_i,
  input  logic [VA_W-1:0] fin_real_i,
  input  logic            fin_ro_i,
  input  logic [VA_W-1:0] va_i,
  input  logic [1:0]      acc_i,
  input  logic [1:0]      code_i,
  input  logic            en_i,
  input  logic            sec_fx_i,
  input  logic            sec_dat_i,
  input  logic [VA_W-1:0] prefix_i,
  output logic            done_o,
  output logic            fault_o,
  output logic [VA_W-1:0] real_o,
  output logic            perm_r_o,
  output logic            perm_w_o,
  output logic            perm_x_o,
  output logic [FC_W-1:0] fault_code_o,
  output logic [VA_W-1:0] fault_word_o
);
  logic            pr, pw, px, prot;
  logic [VA_W-1:0] word_base, real_rel;

  always_comb begin
    pr = 1'b1;
    pw = !(en_i && fin_ro_i);
    px = 1'b1;
    if (en_i && sec_fx_i) begin pr = 1'b0; pw = 1'b0; end
    if (en_i && sec_dat_i) px = 1'b0;
    prot      = fin_i && !fin_fault_i && (acc_i == ACC_WR) && !pw;
    word_base = va_i | VA_W'(code_i);
    real_rel  = (fin_real_i < LOW_LIMIT) ? fin_real_i + prefix_i : fin_real_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      fault_o      <= 1'b0;
      real_o       <= '0;
      perm_r_o     <= 1'b0;
      perm_w_o     <= 1'b0;
      perm_x_o     <= 1'b0;
      fault_code_o <= '0;
      fault_word_o <= '0;
    end else begin
      done_o  <= fin_i && !fin_fault_i && !prot;
      fault_o <= fin_i && (fin_fault_i || prot);
      if (fin_i) begin
        real_o       <= real_rel;
        perm_r_o     <= pr;
        perm_w_o     <= pw;
        perm_x_o     <= px;
        fault_code_o <= prot ? FC_PROT : fin_code_i;
        fault_word_o <= prot ? (word_base | VA_W'(4)) : word_base;
      end
    end
  end

  AST_WRITE_HAS_W: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (acc_i == ACC_WR) |-> perm_w_o); // R11
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [63:0] req_va_i,
  input  logic [1:0]  req_acc_i,
  input  logic [1:0]  req_mode_i,
  input  logic        req_xlat_en_i,
  input  logic        req_wide_i,
  input  logic [63:0] cr_primary_i,
  input  logic [63:0] cr_secondary_i,
  input  logic [63:0] cr_home_i,
  input  logic [63:0] prefix_i,
  output logic        mem_req_o,
  output logic [63:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [63:0] mem_rdata_i,
  output logic        done_o,
  output logic [63:0] real_addr_o,
  output logic        perm_r_o,
  output logic        perm_w_o,
  output logic        perm_x_o,
  output logic        fault_o,
  output logic [7:0]  fault_code_o,
  output logic [63:0] fault_word_o
);
  logic            accept;
  logic [VA_W-1:0] va_q, ce_q, fin_real;
  logic [1:0]      acc_q, code_q;
  logic            en_q, mode_bad_q, sec_fx_q, sec_dat_q;
  logic            fin, fin_fault, fin_ro;
  logic [FC_W-1:0] fin_code;

  ptw_front u_front (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept),
    .va_i(req_va_i), .acc_i(req_acc_i), .mode_i(req_mode_i),
    .en_i(req_xlat_en_i), .wide_i(req_wide_i),
    .cr_pri_i(cr_primary_i), .cr_sec_i(cr_secondary_i), .cr_home_i(cr_home_i),
    .va_o(va_q), .ce_o(ce_q), .acc_o(acc_q), .code_o(code_q), .en_o(en_q),
    .mode_bad_o(mode_bad_q), .sec_fx_o(sec_fx_q), .sec_dat_o(sec_dat_q)
  );

  ptw_walker u_walker (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .ready_o(req_ready_o), .accept_o(accept),
    .en_i(en_q), .mode_bad_i(mode_bad_q), .va_i(va_q), .ce_i(ce_q),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .fin_o(fin), .fin_fault_o(fin_fault), .fin_code_o(fin_code),
    .fin_real_o(fin_real), .fin_ro_o(fin_ro)
  );

  ptw_finish u_finish (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fin_i(fin), .fin_fault_i(fin_fault), .fin_code_i(fin_code),
    .fin_real_i(fin_real), .fin_ro_i(fin_ro),
    .va_i(va_q), .acc_i(acc_q), .code_i(code_q), .en_i(en_q),
    .sec_fx_i(sec_fx_q), .sec_dat_i(sec_dat_q), .prefix_i(prefix_i),
    .done_o(done_o), .fault_o(fault_o), .real_o(real_addr_o),
    .perm_r_o(perm_r_o), .perm_w_o(perm_w_o), .perm_x_o(perm_x_o),
    .fault_code_o(fault_code_o), .fault_word_o(fault_word_o)
  );

  AST_RESULT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> req_ready_o); // R1
endmodule

// File: tb/ptw_top_bench.sv
`timescale 1ns/1ps
module ptw_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0, req_mode = '0;
  logic        req_en = 1'b0, req_wide = 1'b1;
  logic [63:0] cr_pri = '0, cr_sec = '0, cr_home = '0;
  logic [63:0] prefix = 64'h0004_0000;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [63:0] mem_addr, mem_rdata = '0;
  logic        done, fault, pr, pw, px;
  logic [63:0] real_addr, fword;
  logic [7:0]  fcode;

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, lat = 0, wcnt = 0;
  logic [63:0] mem [logic [63:0]];

  logic        o_done, o_fault, o_r, o_w, o_x;
  logic [63:0] o_real, o_word;
  logic [7:0]  o_code;
  int          o_reads;

  always #2 clk = ~clk;

  ptw_top u_ptw_top (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .req_acc_i(req_acc), .req_mode_i(req_mode),
    .req_xlat_en_i(req_en), .req_wide_i(req_wide),
    .cr_primary_i(cr_pri), .cr_secondary_i(cr_sec), .cr_home_i(cr_home),
    .prefix_i(prefix), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .real_addr_o(real_addr), .perm_r_o(pr), .perm_w_o(pw),
    .perm_x_o(px), .fault_o(fault), .fault_code_o(fcode), .fault_word_o(fword)
  );

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h420;
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_rvalid) begin
      if (wcnt >= lat) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd(mem_addr);
        rd_cnt     <= rd_cnt + 1;
        wcnt       <= 0;
      end else wcnt <= wcnt + 1;
    end else mem_rvalid <= 1'b0;
  end

  function automatic logic [63:0] b_off(input int k, input logic [63:0] va);
    case (k)
      3: return (va >> 50) & 64'h3FF8;
      2: return (va >> 39) & 64'h3FF8;
      1: return (va >> 28) & 64'h3FF8;
      default: return (va >> 17) & 64'h3FF8;
    endcase
  endfunction
  function automatic logic [63:0] tbl_at(input logic [63:0] root, input int st, input int k);
    return root + (64'(st - k) << 20);
  endfunction

  task automatic map(input logic [63:0] root, input int st, input logic [63:0] va,
                     input logic [63:0] pte);
    for (int k = st; k >= 0; k--)
      mem[tbl_at(root, st, k) + b_off(k, va)] = tbl_at(root, st, k - 1) | (64'(k) << 2);
    mem[tbl_at(root, st, -1) + ((va >> 9) & 64'h07F8)] = pte;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] mode,
                     input logic en, input logic wide);
    int r0, n;
    @(negedge clk);
    req_va = va; req_acc = acc; req_mode = mode; req_en = en; req_wide = wide;
    req_valid = 1'b1; r0 = rd_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!(done || fault) && n < 500) begin @(negedge clk); n++; end
    if (n >= 500) chk("R1 timeout", 1, 0);
    o_done = done; o_fault = fault; o_real = real_addr; o_r = pr; o_w = pw; o_x = px;
    o_code = fcode; o_word = fword; o_reads = rd_cnt - r0;
    @(negedge clk);
    chk("R1 single pulse", {62'b0, done, fault}, 0);
  endtask

  task automatic exp_done(input string tag, input logic [63:0] ra, input logic [2:0] rwx,
                          input int reads);
    chk({tag, " done"}, {62'b0, o_done, o_fault}, 64'd2);
    chk({tag, " real"}, o_real, ra);
    chk({tag, " rwx"}, {61'b0, o_r, o_w, o_x}, 64'(rwx));
    chk({tag, " reads"}, 64'(o_reads), 64'(reads));
  endtask

  task automatic exp_fault(input string tag, input logic [7:0] code, input logic [63:0] w,
                           input int reads);
    chk({tag, " fault"}, {62'b0, o_done, o_fault}, 64'd1);
    chk({tag, " code"}, 64'(o_code), 64'(code));
    chk({tag, " word"}, o_word, w);
    chk({tag, " reads"}, 64'(o_reads), 64'(reads));
  endtask

  task automatic t_reset;
    chk("R1 reset ready", 64'(req_ready), 1);
    chk("R1 reset done/fault", {62'b0, done, fault}, 0);
    chk("R14 reset mem_req", 64'(mem_req), 0);
  endtask

  task automatic t_off;
    run(64'h0000_1234_5678_9ABC, 2'd0, 2'd0, 1'b0, 1'b1);
    exp_done("R2 off", 64'h0000_1234_5678_9000, 3'b111, 0);
    run(64'h0000_1234_5678_9ABC, 2'd1, 2'd1, 1'b0, 1'b1);
    exp_done("R2 off mode ignored", 64'h0000_1234_5678_9000, 3'b111, 0);
  endtask

  task automatic t_narrow;
    run(64'hFFFF_FFFF_8000_1ABC, 2'd0, 2'd0, 1'b0, 1'b0);
    exp_done("R3 R13 narrow low", 64'h0004_1000, 3'b111, 0);
    run(64'h0000_0000_F234_5678, 2'd0, 2'd0, 1'b0, 1'b0);
    exp_done("R3 narrow", 64'h7234_5000, 3'b111, 0);
  endtask

  task automatic t_walk;
    logic [63:0] va = 64'h0123_4567_89AB_C000;
    map(64'h1000_0000, 3, va, 64'h0ABC_D000);
    cr_pri = 64'h1000_0000 | (64'd3 << 2);
    run(va, 2'd0, 2'd0, 1'b1, 1'b1);
    exp_done("R7 five-tier read", 64'h0ABC_D000, 3'b111, 5);
    run(va, 2'd1, 2'd0, 1'b1, 1'b1);
    exp_done("R7 five-tier write", 64'h0ABC_D000, 3'b111, 5);
    lat = 3;
    run(va, 2'd0, 2'd0, 1'b1, 1'b1);
    exp_done("R14 stalled memory", 64'h0ABC_D000, 3'b111, 5);
    lat = 0;
  endtask

  task automatic t_ro;
    logic [63:0] va = 64'h0000_0345_6000_0000;
    map(64'h1800_0000, 2, va, 64'h0BBB_B200);
    cr_pri = 64'h1800_0000 | (64'd2 << 2);
    run(va, 2'd0, 2'd0, 1'b1, 1'b1);
    exp_done("R9 read-only page", 64'h0BBB_B000, 3'b101, 4);
    run(va, 2'd1, 2'd0, 1'b1, 1'b1);
    exp_fault("R11 write protect", 8'h04, va | 64'd5, 4);
  endtask

  task automatic t_seg_home;
    logic [63:0] va = 64'h1234_5000;
    map(64'h2000_0000, 0, va, 64'h0000_1000);
    cr_home = 64'h2000_0000;
    run(va, 2'd0, 2'd3, 1'b1, 1'b1);
    exp_done("R13 segment start prefix", 64'h0004_1000, 3'b111, 2);
  endtask

  task automatic t_range;
    cr_pri = 64'h3000_0000 | (64'd2 << 2);
    run(64'h0020_0000_0000_0000, 2'd0, 2'd0, 1'b1, 1'b1);
    exp_fault("R5 middle range", 8'h12, 64'h0020_0000_0000_0001, 0);
    cr_pri = 64'h3000_0000 | (64'd1 << 2);
    run(64'h0000_0400_0000_0000, 2'd0, 2'd0, 1'b1, 1'b1);
    exp_fault("R5 inner range", 8'h12, 64'h0000_0400_0000_0001, 0);
    run(64'h0000_03FF_FFFF_F000, 2'd0, 2'd0, 1'b1, 1'b1);
    exp_fault("R5 R8 inner edge passes", 8'h10, 64'h0000_03FF_FFFF_F001, 1);
    cr_pri = 64'h3000_0000;
    run(64'h8000_0000, 2'd0, 2'd0, 1'b1, 1'b1);
    exp_fault("R5 segment range", 8'h12, 64'h8000_0001, 0);
  endtask

  task automatic t_real;
    cr_pri = 64'h20;
    run(64'h0123_4000, 2'd0, 2'd0, 1'b1, 1'b1);
    exp_done("R6 real space", 64'h0123_4000, 3'b111, 0);
    cr_pri = 64'h20 | (64'd3 << 2);
    run(64'h8000_0000_0000_5000, 2'd1, 2'd0, 1'b1, 1'b1);
    exp_done("R6 real space wide", 64'h8000_0000_0000_5000, 3'b111, 0);
  endtask

  task automatic t_entry_faults;
    logic [63:0] va = 64'h0246_8ACE_0000_0000;
    logic [63:0] a;
    map(64'h4000_0000, 3, va, 64'h0CCC_C000);
    cr_home = 64'h4000_0000 | (64'd3 << 2);
    a = tbl_at(64'h4000_0000, 3, 2) + b_off(2, va);
    mem[a] = mem[a] | 64'h20;
    run(va, 2'd0, 2'd3, 1'b1, 1'b1);
    exp_fault("R8 R12 invalid region", 8'h10, va | 64'd3, 2);
    mem[a] = mem[a] & ~64'h2C | 64'h4;
    run(va, 2'd0, 2'd3, 1'b1, 1'b1);
    exp_fault("R8 type mismatch", 8'h12, va | 64'd3, 2);
    mem[a] = (mem[a] & ~64'hC) | 64'h8;
    a = tbl_at(64'h4000_0000, 3, -1) + ((va >> 9) & 64'h07F8);
    mem[a] = mem[a] | 64'h400;
    run(va, 2'd0, 2'd3, 1'b1, 1'b1);
    exp_fault("R9 invalid page", 8'h11, va | 64'd3, 5);
  endtask

  task automatic t_secondary;
    logic [63:0] va  = 64'h0000_0012_3456_7000;
    logic [63:0] va2 = 64'h0000_0022_2222_2000;
    map(64'h5000_0000, 1, va, 64'h0077_7000);
    map(64'h6000_0000, 1, va, 64'h0088_8200);
    cr_pri = 64'h5000_0000 | (64'd1 << 2);
    cr_sec = 64'h6000_0000 | (64'd1 << 2);
    run(va, 2'd2, 2'd2, 1'b1, 1'b1);
    exp_done("R10 secondary fetch", 64'h0077_7000, 3'b001, 3);
    run(va, 2'd0, 2'd2, 1'b1, 1'b1);
    exp_done("R10 secondary read", 64'h0088_8000, 3'b100, 3);
    run(va, 2'd1, 2'd2, 1'b1, 1'b1);
    exp_fault("R11 secondary write protect", 8'h04, va | 64'd6, 3);
    run(va2, 2'd2, 2'd2, 1'b1, 1'b1);
    exp_fault("R12 secondary fetch code", 8'h10, va2 | 64'd1, 1);
    run(va2, 2'd0, 2'd2, 1'b1, 1'b1);
    exp_fault("R12 secondary data code", 8'h10, va2 | 64'd2, 1);
  endtask

  task automatic t_mode;
    run(64'h0000_0000_1234_5678, 2'd0, 2'd1, 1'b1, 1'b1);
    exp_fault("R4 unsupported mode", 8'h7F, 64'h0000_0000_1234_5000, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off();
    t_narrow();
    t_walk();
    t_ro();
    t_seg_home();
    t_range();
    t_real();
    t_entry_faults();
    t_secondary();
    t_mode();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule